// File: doc/BRIEF.md
# Pulse-Swallow RF Divider

This block divides a fast input rate by a programmable whole number and emits one pulse per divide cycle for a phase comparator. The input rate is modelled as a single-cycle enable `rf_en` on the system clock; every enabled cycle stands for one RF input cycle. Inside, a small counter plays the part of a dual-modulus prescaler that divides by 9 while the modulus-control line is high and by 8 otherwise. A 3-bit swallow counter and an 11-bit main counter steer that line, so the total ratio is 8·M + A.

The 14-bit ratio word is read transparently: there is no load strobe. The word is sampled only at the reload that closes each divide cycle, so a change takes effect from the next divide cycle. The legal ratios run from 56 to 16383. A main count below 7 raises a range flag, and the divider then follows a fixed fallback rule.

Top module: `psd_divider`

## Requirements
- R1: After reset `div_pulse` and `mod_ctl` are low, and the first rising edge of `div_pulse` comes after exactly 8 enabled RF cycles.
- R2: With M = `prog_bus[13:3]` in 7..2047 and A = `prog_bus[2:0]`, consecutive rising edges of `div_pulse` are exactly 8·M + A enabled RF cycles apart. This covers the extremes 56 (M=7, A=0) and 63 (M=7, A=7).
- R3: Each `div_pulse` stays high for exactly 8 enabled RF cycles, and it rises only at the close of a divide cycle.
- R4: Within each divide cycle, `mod_ctl` is high for exactly 9·A enabled RF cycles, which is the first A prescaler cycles. It changes only at a prescaler cycle boundary.
- R5: Cycles with `rf_en` low change nothing: both outputs hold their value, and the ratio counts enabled cycles only, whatever the gap pattern.
- R6: `prog_bus` is sampled only at the divide-cycle reload. A value applied right after a pulse rises leaves the current cycle at the old ratio and sets the ratio of the cycle after it.
- R7: `range_err` is high exactly when M < 7. It follows `prog_bus` in the same cycle.
- R8: With M < 7 the divider uses Me = max(M,1) and Ae = min(A,Me). The period is 8·Me + Ae and the `mod_ctl` time is 9·Ae enabled cycles.
- R9: An all-ones bus (the default for unconnected inputs) gives a period of 16383 and a `mod_ctl` time of 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rf_en | input | 1 | One enabled cycle per RF input cycle |
| prog_bus | input | 14 | Ratio word: [2:0] swallow count A, [13:3] main count M |
| div_pulse | output | 1 | Divided output pulse, 8 enabled cycles wide |
| mod_ctl | output | 1 | Prescaler modulus select, high = divide by 9 |
| range_err | output | 1 | Main count below 7 |

## Verification
The terminal tick of the last prescaler cycle does two things in one clock edge: it reloads both counters from the bus and it starts the output pulse. The pulse counter is also consumed by ordinary enables, so reload and decrement can collide. The bench changes the bus in the cycle right after a pulse rises. It then checks that one whole period still follows the old word and the next one follows the new word, with the pulse width and the `mod_ctl` time checked in each. Random gaps in `rf_en` move the terminal tick to arbitrary clock cycles, and the period is judged in enabled cycles only.

// File: rtl/psd_pkg.sv
package psd_pkg;
  // default split of the ratio word and the prescaler low modulus
  localparam int unsigned SWAL_W_DEF  = 3;
  localparam int unsigned MAIN_W_DEF  = 11;
  localparam int unsigned PRE_LOW_DEF = 8;
  localparam int unsigned M_MIN_DEF   = 7;
endpackage

// File: rtl/psd_ratio_decode.sv
module psd_ratio_decode #(
  parameter int unsigned SWAL_W = psd_pkg::SWAL_W_DEF,
  parameter int unsigned MAIN_W = psd_pkg::MAIN_W_DEF,
  parameter int unsigned M_MIN  = psd_pkg::M_MIN_DEF,
  localparam int unsigned BUS_W = SWAL_W + MAIN_W
) (
  input  logic [BUS_W-1:0]  bus_i,
  output logic [MAIN_W-1:0] main_eff_o,
  output logic [SWAL_W-1:0] swal_eff_o,
  output logic              range_err_o
);
  logic [MAIN_W-1:0] main_raw;
  logic [SWAL_W-1:0] swal_raw;
  logic [MAIN_W-1:0] swal_ext;

  always_comb begin
    main_raw    = bus_i[BUS_W-1:SWAL_W];
    swal_raw    = bus_i[SWAL_W-1:0];
    range_err_o = (main_raw < MAIN_W'(M_MIN));
    // fallback: a zero main count acts as one
    main_eff_o  = (main_raw == '0) ? MAIN_W'(1) : main_raw;
    swal_ext    = {{(MAIN_W-SWAL_W){1'b0}}, swal_raw};
    // never swallow more cycles than the main count holds
    swal_eff_o  = (swal_ext > main_eff_o) ? main_eff_o[SWAL_W-1:0] : swal_raw;
  end
endmodule

// File: rtl/psd_prescaler.sv
module psd_prescaler #(
  parameter int unsigned PRE_LOW = psd_pkg::PRE_LOW_DEF,
  localparam int unsigned PC_W   = $clog2(PRE_LOW + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic mod_hi,
  output logic cyc_end
);
  logic [PC_W-1:0] cnt_q, cnt_d;
  logic [PC_W-1:0] term;

  always_comb begin
    term    = mod_hi ? PC_W'(PRE_LOW) : PC_W'(PRE_LOW - 1);
    cyc_end = tick_en && (cnt_q == term);
    cnt_d   = cnt_q;
    if (tick_en) cnt_d = cyc_end ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2
  pre_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= PC_W'(PRE_LOW));
endmodule

// File: rtl/psd_swallow_ctrl.sv
module psd_swallow_ctrl #(
  parameter int unsigned SWAL_W = psd_pkg::SWAL_W_DEF,
  parameter int unsigned MAIN_W = psd_pkg::MAIN_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pre_end,
  input  logic [MAIN_W-1:0] main_ld,
  input  logic [SWAL_W-1:0] swal_ld,
  output logic              mod_hi,
  output logic              div_end
);
  logic [MAIN_W-1:0] main_q, main_d;
  logic [SWAL_W-1:0] swal_q, swal_d;

  always_comb begin
    mod_hi  = (swal_q != '0);
    div_end = pre_end && (main_q <= MAIN_W'(1));
    main_d  = main_q;
    swal_d  = swal_q;
    if (div_end) begin
      main_d = main_ld;
      swal_d = swal_ld;
    end else if (pre_end) begin
      main_d = main_q - 1'b1;
      if (swal_q != '0) swal_d = swal_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_q <= MAIN_W'(1);
      swal_q <= '0;
    end else begin
      main_q <= main_d;
      swal_q <= swal_d;
    end
  end

  // R4
  swal_le_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
    {{(MAIN_W-SWAL_W){1'b0}}, swal_q} <= main_q);
  // R4
  mod_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mod_hi) |-> $past(pre_end));
endmodule

// File: rtl/psd_pulse_shaper.sv
module psd_pulse_shaper #(
  parameter int unsigned PULSE_LEN = psd_pkg::PRE_LOW_DEF,
  localparam int unsigned PL_W     = $clog2(PULSE_LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic start,
  output logic pulse_o
);
  logic [PL_W-1:0] left_q, left_d;

  always_comb begin
    left_d = left_q;
    if (start)                         left_d = PL_W'(PULSE_LEN);
    else if (tick_en && left_q != '0)  left_d = left_q - 1'b1;
    pulse_o = (left_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left_q <= '0;
    else        left_q <= left_d;
  end

  // R3
  pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_o) |-> $past(start));
endmodule

// File: rtl/psd_divider.sv
module psd_divider #(
  parameter int unsigned SWAL_W  = psd_pkg::SWAL_W_DEF,
  parameter int unsigned MAIN_W  = psd_pkg::MAIN_W_DEF,
  parameter int unsigned PRE_LOW = psd_pkg::PRE_LOW_DEF,
  parameter int unsigned M_MIN   = psd_pkg::M_MIN_DEF,
  localparam int unsigned BUS_W  = SWAL_W + MAIN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rf_en,
  input  logic [BUS_W-1:0] prog_bus,
  output logic             div_pulse,
  output logic             mod_ctl,
  output logic             range_err
);
  logic [1:0]        rst_sync_q;
  logic              rst_i_n;
  logic [MAIN_W-1:0] main_eff;
  logic [SWAL_W-1:0] swal_eff;
  logic              pre_end;
  logic              mod_hi;
  logic              div_end;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  psd_ratio_decode #(.SWAL_W(SWAL_W), .MAIN_W(MAIN_W), .M_MIN(M_MIN)) u_dec (
    .bus_i(prog_bus), .main_eff_o(main_eff), .swal_eff_o(swal_eff),
    .range_err_o(range_err));

  psd_prescaler #(.PRE_LOW(PRE_LOW)) u_pre (
    .clk(clk), .rst_n(rst_i_n), .tick_en(rf_en), .mod_hi(mod_hi),
    .cyc_end(pre_end));

  psd_swallow_ctrl #(.SWAL_W(SWAL_W), .MAIN_W(MAIN_W)) u_swl (
    .clk(clk), .rst_n(rst_i_n), .pre_end(pre_end), .main_ld(main_eff),
    .swal_ld(swal_eff), .mod_hi(mod_hi), .div_end(div_end));

  psd_pulse_shaper #(.PULSE_LEN(PRE_LOW)) u_pls (
    .clk(clk), .rst_n(rst_i_n), .tick_en(rf_en), .start(div_end),
    .pulse_o(div_pulse));

  assign mod_ctl = mod_hi;

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    !rf_en |=> ($stable(div_pulse) && $stable(mod_ctl)));
endmodule

// File: tb/tb_psd_divider.sv
module tb_psd_divider;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        rf_en;
  logic [13:0] prog_bus;
  logic        div_pulse, mod_ctl, range_err;
  int total = 0;
  int bad   = 0;

  psd_divider dut (.clk(clk), .rst_n(rst_n), .rf_en(rf_en), .prog_bus(prog_bus),
                   .div_pulse(div_pulse), .mod_ctl(mod_ctl), .range_err(range_err));

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic logic [13:0] word(input int m, input int a);
    return {m[10:0], a[2:0]};
  endfunction

  // counts enabled cycles between rises; checks nchk periods after nskip rises
  task automatic measure(input int nskip, input int nchk, input int exp_p,
                         input int exp_mod, input string rq, input bit gaps);
    int cnt = 0, wcnt = 0, mcnt = 0, rises = 0, guard = 0;
    bit prev = div_pulse;
    bit en;
    forever begin
      @(negedge clk);
      guard++;
      if (guard > 60000) begin
        check(1'b0, {rq, " watchdog"}, guard, 0);
        break;
      end
      if (!prev && div_pulse) begin
        rises++;
        if (rises > nskip) begin
          check(cnt == exp_p, {rq, " period"}, cnt, exp_p);
          check(wcnt == 8, "R3 width", wcnt, 8);
          check(mcnt == exp_mod, "R4 mod_ctl time", mcnt, exp_mod);
        end
        cnt = 0; wcnt = 0; mcnt = 0;
        if (rises >= nskip + nchk) break;
      end
      prev = div_pulse;
      en = gaps ? ($urandom % 3 != 0) : 1'b1;
      rf_en = en;
      if (en) begin
        cnt++;
        if (div_pulse) wcnt++;
        if (mod_ctl) mcnt++;
      end
    end
    rf_en = 1'b0;
  endtask

  task automatic t_reset();
    int cnt = 0;
    check(div_pulse == 1'b0, "R1 pulse low", div_pulse, 0);
    check(mod_ctl == 1'b0, "R1 mod low", mod_ctl, 0);
    while (!div_pulse && cnt < 100) begin
      rf_en = 1'b1;
      cnt++;
      @(negedge clk);
    end
    rf_en = 1'b0;
    check(cnt == 8, "R1 first pulse", cnt, 8);
  endtask

  task automatic t_default();
    check(range_err == 1'b0, "R7 all ones", range_err, 0);
    measure(0, 1, 16383, 63, "R9", 1'b0);
  endtask

  task automatic t_legal(input int m, input int a, input bit gaps);
    prog_bus = word(m, a);
    #1 check(range_err == 1'b0, "R7 legal", range_err, 0);
    measure(1, 2, 8 * m + a, 9 * a, "R2", gaps);
  endtask

  task automatic t_switch();
    prog_bus = word(10, 3);
    measure(1, 1, 83, 27, "R6 first", 1'b0);
    prog_bus = word(20, 5);
    measure(0, 1, 83, 27, "R6 old", 1'b1);
    measure(0, 1, 165, 45, "R6 new", 1'b1);
  endtask

  task automatic t_idle();
    bit p, mc;
    prog_bus = word(9, 6);
    measure(1, 1, 78, 54, "R5 pre", 1'b0);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      rf_en = 1'b1;
    end
    rf_en = 1'b0;
    @(negedge clk);
    p = div_pulse; mc = mod_ctl;
    for (int i = 0; i < 20; i++) begin
      prog_bus = word(i, i);
      @(negedge clk);
      check(div_pulse == p && mod_ctl == mc, "R5 hold", {div_pulse, mod_ctl}, {p, mc});
    end
    prog_bus = word(9, 6);
    measure(1, 1, 78, 54, "R5 gaps", 1'b1);
  endtask

  task automatic t_error(input int m, input int a);
    int me = (m == 0) ? 1 : m;
    int ae = (a > me) ? me : a;
    prog_bus = word(m, a);
    #1 check(range_err == 1'b1, "R7 low main", range_err, 1);
    measure(1, 1, 8 * me + ae, 9 * ae, "R8", 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; rf_en = 1'b0; prog_bus = 14'h3FFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_default();
    t_legal(7, 0, 1'b0);
    t_legal(7, 7, 1'b1);
    for (int k = 0; k < 3; k++) t_legal(7 + int'($urandom % 300), int'($urandom % 8), 1'b1);
    t_switch();
    t_idle();
    t_error(3, 5);
    t_error(0, 2);
    t_error(6, 7);
    prog_bus = word(7, 0);
    #1 check(range_err == 1'b0, "R7 edge", range_err, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #3_600_000;
    total++; bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule